// File: doc/BRIEF.md
# Two-Operand Integer ALU with Shifter

This block is a 32-bit integer execution unit that works in destructive two-operand form. Every operation reads a destination operand D and, for binary operations, a source operand S. It produces the new value of D. The new value is registered and appears one cycle after a valid request, together with zero, sign, carry and overflow flags computed for the selected operand size.

The operation set has three groups. The binary group covers add, subtract (D minus S), xor, or and and. The unary group covers increment, decrement, negate and complement. The shift group covers left shift and both right shifts. The shift count comes either from an 8-bit immediate or from the low byte of a count register, and only its low five bits are used. Each request picks a byte, word or long size. Byte and word operations change only the low bits, and the untouched upper bits of D pass through to the result.

Top module: `twoop_alu`

## Requirements
- R1: A request with `in_valid` high produces `out_valid` high and the new result and flags on the next clock. A cycle without `in_valid` drives `out_valid` low and holds `result` and the flags.
- R2: Opcode 0 computes D+S. Opcode 1 computes D−S, never S−D; for example 0x100 − 3 = 0xFD.
- R3: Opcode 2 computes D xor S, opcode 3 computes D or S, and opcode 4 computes D and S; for example 0xAB xor 0x100 = 0x1AB.
- R4: Opcode 5 computes D+1, opcode 6 computes D−1, opcode 7 computes −D, and opcode 8 computes ~D. S is not used by these opcodes.
- R5: Opcodes 9 and 10 are both a left shift that fills with zeros. Opcode 11 is a right shift that fills with the sign bit of the sized operand. Opcode 12 is a right shift that fills with zeros.
- R6: With `cnt_sel`=1 the shift count is `cnt_imm`. With `cnt_sel`=0 it is `cnt_reg[7:0]`, and the upper bytes of `cnt_reg` are ignored. Only the low five count bits are used, giving a range of 0 to 31. A count of 0 leaves the sized value unchanged.
- R7: `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the size equal the same bits of D. Bits of S above the size have no effect.
- R8: The flags `flag_z` and `flag_s` show whether the sized result is zero and the value of its top bit. For add and increment, `flag_c` is the carry out of the sized width. For subtract, decrement and negate, it is the unsigned borrow; negate is taken as 0−D. `flag_v` is signed overflow at the sized width. For logic and shift opcodes, `flag_c` and `flag_v` are 0.
- R9: Opcodes 13 to 15 return D unchanged with all four flags 0.
- R10: While `rst` is high at a clock edge, `out_valid`, `result` and all flags are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 4 | Operation select |
| size | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| dst_val | input | 32 | Destination operand D |
| src_val | input | 32 | Source operand S |
| cnt_sel | input | 1 | 1: shift count from immediate, 0: from count register |
| cnt_imm | input | 8 | Immediate shift count |
| cnt_reg | input | 32 | Count register; only its low byte is used |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | New value of D |
| flag_z | output | 1 | Sized result is zero |
| flag_s | output | 1 | Top bit of the sized result |
| flag_c | output | 1 | Carry or borrow |
| flag_v | output | 1 | Signed overflow |

## Verification
The unit holds no state apart from its output register. A wrong size mask or a wrong operand mux therefore shows on `result` or the flags in the cycle right after the offending request. The clearest sign is upper destination bits that change on a byte or word request. Carry and overflow are taken at the sized top bit, so an error in the width decode shows up as wrong flags at the 8-bit and 16-bit boundaries even when the low result bits are correct. The shift count path is covered with both count sources, with counts above 31, and with counts larger than the operand width.

// File: rtl/twoop_alu_pkg.sv
package twoop_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_XOR = 4'd2, OP_OR  = 4'd3,
    OP_AND = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_NEG = 4'd7,
    OP_NOT = 4'd8, OP_SHL = 4'd9, OP_SAL = 4'd10, OP_SAR = 4'd11,
    OP_SHR = 4'd12
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0, SH_ARITH = 2'd1, SH_LOGIC = 2'd2
  } shift_kind_e;
endpackage

// File: rtl/twoop_arith.sv
module twoop_arith #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              is_sub,
  input  logic [IDX_W-1:0]  msb_idx,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              ovf_out
);
  logic [DATA_W:0] add_w, sub_w;
  logic [IDX_W:0]  cpos;
  logic            a_top, b_top, r_top;
  logic            unused_sub_top;

  assign add_w = {1'b0, a_in} + {1'b0, b_in};
  assign sub_w = {1'b0, a_in} - {1'b0, b_in};
  assign cpos  = {1'b0, msb_idx} + (IDX_W+1)'(1);
  assign unused_sub_top = sub_w[DATA_W];

  assign sum_out = is_sub ? sub_w[DATA_W-1:0] : add_w[DATA_W-1:0];
  assign a_top   = a_in[msb_idx];
  assign b_top   = b_in[msb_idx];
  assign r_top   = sum_out[msb_idx];

  always_comb begin
    if (is_sub) begin
      carry_out = (a_in < b_in);
      ovf_out   = (a_top != b_top) && (r_top != a_top);
    end else begin
      carry_out = add_w[cpos];
      ovf_out   = (a_top == b_top) && (r_top != a_top);
    end
  end
endmodule

// File: rtl/twoop_logic.sv
module twoop_logic #(
  parameter int DATA_W = 32
) (
  input  twoop_alu_pkg::alu_op_e op,
  input  logic [DATA_W-1:0]      d_in,
  input  logic [DATA_W-1:0]      s_in,
  output logic [DATA_W-1:0]      res_out
);
  import twoop_alu_pkg::*;
  always_comb begin
    case (op)
      OP_XOR:  res_out = d_in ^ s_in;
      OP_OR:   res_out = d_in | s_in;
      OP_AND:  res_out = d_in & s_in;
      default: res_out = ~d_in;
    endcase
  end
endmodule

// File: rtl/twoop_shift.sv
module twoop_shift #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]        val_in,
  input  logic [DATA_W-1:0]        width_mask,
  input  logic [IDX_W-1:0]         msb_idx,
  input  logic [IDX_W-1:0]         count,
  input  twoop_alu_pkg::shift_kind_e kind,
  output logic [DATA_W-1:0]        res_out
);
  import twoop_alu_pkg::*;
  logic [DATA_W-1:0] sext;

  assign sext = val_in[msb_idx] ? (val_in | ~width_mask) : val_in;

  always_comb begin
    case (kind)
      SH_ARITH: res_out = DATA_W'($signed(sext) >>> count);
      SH_LOGIC: res_out = val_in >> count;
      default:  res_out = val_in << count;
    endcase
  end

  // R6
  always_comb begin
    if (count == '0) begin
      zero_count_chk: assert ((res_out & width_mask) == val_in);
    end
  end
endmodule

// File: rtl/twoop_alu.sv
module twoop_alu #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic              cnt_sel,
  input  logic [CNT_W-1:0]  cnt_imm,
  input  logic [DATA_W-1:0] cnt_reg,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_c,
  output logic              flag_v
);
  import twoop_alu_pkg::*;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int B_W   = DATA_W / 4;
  localparam int H_W   = DATA_W / 2;
  localparam logic [DATA_W-1:0] MASK_B = {{(DATA_W-B_W){1'b0}}, {B_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_H = {{(DATA_W-H_W){1'b0}}, {H_W{1'b1}}};

  alu_op_e           op;
  logic [DATA_W-1:0] mask, dm, sm;
  logic [IDX_W-1:0]  msb_idx;
  logic [CNT_W-1:0]  cnt_raw;
  logic [IDX_W-1:0]  cnt;
  logic              unused_cnt;

  assign op = alu_op_e'(opcode);

  always_comb begin
    case (size)
      2'd0:    begin mask = MASK_B;  msb_idx = IDX_W'(B_W - 1);    end
      2'd1:    begin mask = MASK_H;  msb_idx = IDX_W'(H_W - 1);    end
      default: begin mask = '1;      msb_idx = IDX_W'(DATA_W - 1); end
    endcase
  end

  assign dm = dst_val & mask;
  assign sm = src_val & mask;

  assign cnt_raw    = cnt_sel ? cnt_imm : cnt_reg[CNT_W-1:0];
  assign cnt        = cnt_raw[IDX_W-1:0];
  assign unused_cnt = ^{cnt_reg[DATA_W-1:CNT_W], cnt_raw[CNT_W-1:IDX_W]};

  // arithmetic operand steering
  logic [DATA_W-1:0] ar_a, ar_b, ar_res;
  logic              ar_sub, ar_c, ar_v;

  always_comb begin
    ar_a = dm;
    ar_b = sm;
    ar_sub = 1'b0;
    case (op)
      OP_SUB: ar_sub = 1'b1;
      OP_INC: ar_b = DATA_W'(1);
      OP_DEC: begin ar_b = DATA_W'(1); ar_sub = 1'b1; end
      OP_NEG: begin ar_a = '0; ar_b = dm; ar_sub = 1'b1; end
      default: ;
    endcase
  end

  twoop_arith #(.DATA_W(DATA_W)) u_arith (
    .a_in(ar_a), .b_in(ar_b), .is_sub(ar_sub), .msb_idx(msb_idx),
    .sum_out(ar_res), .carry_out(ar_c), .ovf_out(ar_v)
  );

  logic [DATA_W-1:0] lg_res;
  twoop_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op), .d_in(dm), .s_in(sm), .res_out(lg_res)
  );

  shift_kind_e       sh_kind;
  logic [DATA_W-1:0] sh_res;
  always_comb begin
    case (op)
      OP_SAR:  sh_kind = SH_ARITH;
      OP_SHR:  sh_kind = SH_LOGIC;
      default: sh_kind = SH_LEFT;
    endcase
  end

  twoop_shift #(.DATA_W(DATA_W)) u_shift (
    .val_in(dm), .width_mask(mask), .msb_idx(msb_idx), .count(cnt),
    .kind(sh_kind), .res_out(sh_res)
  );

  // result selection and merge with the untouched upper destination bits
  logic [DATA_W-1:0] raw, nxt_res, sized;
  logic              nxt_c, nxt_v, nxt_z, nxt_s, legal;

  always_comb begin
    raw = dm; nxt_c = 1'b0; nxt_v = 1'b0; legal = 1'b1;
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: begin
        raw = ar_res; nxt_c = ar_c; nxt_v = ar_v;
      end
      OP_XOR, OP_OR, OP_AND, OP_NOT: raw = lg_res;
      OP_SHL, OP_SAL, OP_SAR, OP_SHR: raw = sh_res;
      default: legal = 1'b0;
    endcase
    sized = raw & mask;
    if (legal) begin
      nxt_res = (dst_val & ~mask) | sized;
      nxt_z   = (sized == '0);
      nxt_s   = sized[msb_idx];
    end else begin
      nxt_res = dst_val;
      nxt_z = 1'b0; nxt_s = 1'b0; nxt_c = 1'b0; nxt_v = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      {flag_z, flag_s, flag_c, flag_v} <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        {flag_z, flag_s, flag_c, flag_v} <= {nxt_z, nxt_s, nxt_c, nxt_v};
      end
    end
  end

  // R1
  valid_pipe_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(result));
  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == 2'd0 && opcode <= 4'd12)
    |=> result[DATA_W-1:B_W] == $past(dst_val[DATA_W-1:B_W]));
  // R8
  logic_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode >= 4'd2 && opcode <= 4'd4) |=> !flag_c && !flag_v);
  // R9
  reserved_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode >= 4'd13) |=> result == $past(dst_val) && !flag_z && !flag_s);
endmodule

// File: tb/test_twoop_alu.sv
module test_twoop_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  size = '0;
  logic [31:0] dst_val = '0, src_val = '0, cnt_reg = '0;
  logic        cnt_sel = 1'b0;
  logic [7:0]  cnt_imm = '0;
  logic        out_valid, flag_z, flag_s, flag_c, flag_v;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  twoop_alu i_twoop_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .size(size),
    .dst_val(dst_val), .src_val(src_val), .cnt_sel(cnt_sel), .cnt_imm(cnt_imm),
    .cnt_reg(cnt_reg), .out_valid(out_valid), .result(result),
    .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_v(flag_v)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic        sel;
    logic [7:0]  imm;
    logic [31:0] creg;
    logic [31:0] dst;
    logic [31:0] src;
    logic [31:0] exp;
    logic [3:0]  flg;   // {Z,S,C,V}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{4'd2,  2'd2, 1'b1, 8'd0,  32'h0,        32'h000000AB, 32'h00000100, 32'h000001AB, 4'b0000, 4'd3},  // R3 xor
    '{4'd1,  2'd2, 1'b1, 8'd0,  32'h0,        32'h00000100, 32'h00000003, 32'h000000FD, 4'b0000, 4'd2},  // R2 D-S
    '{4'd1,  2'd2, 1'b1, 8'd0,  32'h0,        32'h00000003, 32'h00000100, 32'hFFFFFF03, 4'b0110, 4'd2},  // R2 borrow
    '{4'd0,  2'd0, 1'b1, 8'd0,  32'h0,        32'h123456FF, 32'h00000001, 32'h12345600, 4'b1010, 4'd7},  // R7 byte add
    '{4'd0,  2'd1, 1'b1, 8'd0,  32'h0,        32'hAAAA7FFF, 32'h00000001, 32'hAAAA8000, 4'b0101, 4'd8},  // R8 word ovf
    '{4'd5,  2'd2, 1'b1, 8'd0,  32'h0,        32'hFFFFFFFF, 32'h12345678, 32'h00000000, 4'b1010, 4'd4},  // R4 inc
    '{4'd6,  2'd0, 1'b1, 8'd0,  32'h0,        32'h55555580, 32'h0,        32'h5555557F, 4'b0001, 4'd4},  // R4 dec
    '{4'd7,  2'd2, 1'b1, 8'd0,  32'h0,        32'h00000001, 32'h0,        32'hFFFFFFFF, 4'b0110, 4'd4},  // R4 neg
    '{4'd7,  2'd0, 1'b1, 8'd0,  32'h0,        32'hCAFE0080, 32'h0,        32'hCAFE0080, 4'b0111, 4'd8},  // R8 neg min
    '{4'd8,  2'd1, 1'b1, 8'd0,  32'h0,        32'h12340F0F, 32'hFFFFFFFF, 32'h1234F0F0, 4'b0100, 4'd4},  // R4 not
    '{4'd3,  2'd0, 1'b1, 8'd0,  32'h0,        32'hFFFFFF00, 32'hAB00003C, 32'hFFFFFF3C, 4'b0000, 4'd7},  // R7 src upper
    '{4'd4,  2'd2, 1'b1, 8'd0,  32'h0,        32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 4'b1000, 4'd3},  // R3 and
    '{4'd9,  2'd2, 1'b1, 8'd4,  32'h0,        32'h8000000F, 32'h0,        32'h000000F0, 4'b0000, 4'd5},  // R5 shl
    '{4'd10, 2'd1, 1'b1, 8'd1,  32'h0,        32'hFFFF4001, 32'h0,        32'hFFFF8002, 4'b0100, 4'd5},  // R5 sal
    '{4'd11, 2'd0, 1'b0, 8'd7,  32'hFFFFFF03, 32'h11223390, 32'h0,        32'h112233F2, 4'b0100, 4'd6},  // R6 reg cnt sar
    '{4'd12, 2'd0, 1'b0, 8'd7,  32'hFFFFFF03, 32'h11223390, 32'h0,        32'h11223312, 4'b0000, 4'd5},  // R5 shr
    '{4'd12, 2'd2, 1'b1, 8'h24, 32'h0,        32'h80000000, 32'h0,        32'h08000000, 4'b0000, 4'd6},  // R6 mask
    '{4'd11, 2'd2, 1'b1, 8'd31, 32'h0,        32'h80000000, 32'h0,        32'hFFFFFFFF, 4'b0100, 4'd5},  // R5 sar 31
    '{4'd11, 2'd0, 1'b1, 8'd20, 32'h0,        32'h00000080, 32'h0,        32'h000000FF, 4'b0100, 4'd5},  // R5 sar wide
    '{4'd9,  2'd2, 1'b1, 8'd0,  32'h0,        32'h12345678, 32'h0,        32'h12345678, 4'b0000, 4'd6},  // R6 zero
    '{4'd13, 2'd2, 1'b1, 8'd0,  32'h0,        32'hDEADBEEF, 32'h1,        32'hDEADBEEF, 4'b0000, 4'd9},  // R9
    '{4'd0,  2'd3, 1'b1, 8'd0,  32'h0,        32'hFFFFFFFF, 32'h00000002, 32'h00000001, 4'b0010, 4'd7},  // R7 size 3
    '{4'd12, 2'd2, 1'b0, 8'd7,  32'h00000F01, 32'h00000008, 32'h0,        32'h00000004, 4'b0000, 4'd6}   // R6 upper ignored
  };

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {out_valid, result, flag_z, flag_s, flag_c, flag_v}, 37'h0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      opcode = VT[i].op; size = VT[i].sz; cnt_sel = VT[i].sel;
      cnt_imm = VT[i].imm; cnt_reg = VT[i].creg;
      dst_val = VT[i].dst; src_val = VT[i].src; in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VT[i].req, i),
            {out_valid, result, flag_z, flag_s, flag_c, flag_v},
            {1'b1, VT[i].exp, VT[i].flg});
    end
    // R1 hold while idle
    in_valid = 1'b0; dst_val = 32'h0BADF00D; opcode = 4'd0;
    @(negedge clk);
    check("R1 idle", {out_valid, result, flag_z, flag_s, flag_c, flag_v},
          {1'b0, 32'h00000004, 4'b0000});
    // R1 latency of one cycle from a fresh request
    opcode = 4'd1; size = 2'd2; dst_val = 32'h10; src_val = 32'h10; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 latency", {out_valid, result, flag_z, flag_s, flag_c, flag_v},
          {1'b1, 32'h0, 4'b1000});
    @(negedge clk);
    check("R1 drop", {36'h0, out_valid}, 37'h0);
    // R10 reset clears a held result
    opcode = 4'd5; dst_val = 32'h7FFFFFFF; in_valid = 1'b1;
    @(negedge clk);
    check("R8 long ovf", {out_valid, result, flag_z, flag_s, flag_c, flag_v},
          {1'b1, 32'h80000000, 4'b0101});
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 clear", {out_valid, result, flag_z, flag_s, flag_c, flag_v}, 37'h0);
    rst = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule